// File: doc/BRIEF.md
# Fully Associative Micro Translation Cache

This block is the first-level address translation cache that sits on one side of a processor core, either the fetch side or the load/store side. Each access presents a virtual address, the current address-space identifier, a read/write flag and a privilege flag. In the same cycle the block answers with the physical address used by the cache tag compare. It may instead report a miss, or a protection fault that the core sees as a prefetch abort or a data abort, depending on the side the instance serves.

All 32 entries are searched at once. Each entry maps a page of 4 KB, 64 KB, 1 MB or 16 MB. A miss is handed to the shared second-level translation cache. The block holds the requester stalled until exactly one refill entry arrives. It writes that entry into the next slot in round-robin order and then retries the held lookup. Protection uses a 16-domain access control word together with the entry's two access-permission bits. A flush input drops every entry in a single cycle.

Top module: `utlb`

## Requirements
- R1: After reset no entry is valid, `stall_o`, `miss_o`, `hit_o`, `pabort_o` and `dabort_o` are low, `fault_o` is 0, and the first lookup misses.
- R2: A hit is answered combinationally in the cycle of the request: `hit_o` is high and, for a 4 KB page, `pa_o[31:12]` is the entry's physical page number and `pa_o[11:0]` is `req_va[11:0]`. `pa_o` is 0 when `hit_o` is low.
- R3: The 2-bit page size code is 0 for 4 KB, 1 for 64 KB, 2 for 1 MB and 3 for 16 MB. For each size, the address bits below the page boundary (16, 20 or 24) are ignored by the match and pass straight into `pa_o`. The entry's physical bits below that boundary are ignored, and the bits above it come from the entry.
- R4: An entry with its global flag clear matches only when `req_asid` equals its stored identifier. A global entry matches under any identifier. When several entries match, the lowest slot wins.
- R5: A valid request that misses raises `miss_o` and `stall_o` in the same cycle. `stall_o` then stays high, and lookup outputs stay low, until a cycle with `refill_valid` high. The cycle after that refill, the held request is looked up again.
- R6: `refill_valid` is ignored when no miss is outstanding: no entry is written.
- R7: Refills fill slots in round-robin order, so the 33rd refill after any point replaces the entry written by the 1st.
- R8: A cycle with `flush` high invalidates every entry at that clock edge. A refill offered in the same cycle is not taken.
- R9: The domain's 2-bit field is `dacr[2*d+1:2*d]` for domain d. Value 01 enforces the access bits. Value 11 grants any access. Values 00 and 10 fault every access, with `fault_o` = 1.
- R10: The access-bit codes are as follows. 0 allows privileged read/write only. 1 allows privileged read/write and user read. 2 allows read/write at any level. 3 allows read at any level. A disallowed access under a checking domain gives `fault_o` = 2, and this includes any write to a read-only page.
- R11: A fault occurs only on a hit. On an instance built with `FETCH_SIDE`=1 it raises `pabort_o`, and otherwise it raises `dabort_o`. The other abort output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present (held while stalled) |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| dacr | input | 32 | Domain access control word, 2 bits per domain |
| flush | input | 1 | Invalidate all entries |
| refill_valid | input | 1 | Refill entry from second-level cache |
| refill_vpn | input | 20 | Refill virtual page number |
| refill_ppn | input | 20 | Refill physical page number |
| refill_asid | input | 8 | Refill address-space identifier |
| refill_global | input | 1 | Refill entry ignores identifier |
| refill_size | input | 2 | Refill page size code |
| refill_domain | input | 4 | Refill domain number |
| refill_ap | input | 2 | Refill access-bit code |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 32 | Physical address |
| miss_o | output | 1 | Miss forwarded to second-level cache |
| stall_o | output | 1 | Requester must hold |
| fault_o | output | 2 | 0 none, 1 domain, 2 permission |
| pabort_o | output | 1 | Prefetch abort (fetch-side instance) |
| dabort_o | output | 1 | Data abort (data-side instance) |

## Verification
A behavioural model of the entry list and the miss state is compared with both a data-side and a fetch-side instance on every cycle. Lookups within one page at different offsets, and across each page size, separate the masking of the match from the masking of the output address. Pairs of identical addresses under different identifiers, with global and private entries, show whether the identifier is used and which slot wins. Walking the domain field through all four codes, and the access bits under every privilege and direction pair, separates domain faults from permission faults. A run of 33 refills shows whether replacement is round-robin.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int ASID_W     = 8;
    localparam int DOM_W      = 4;
    localparam int DOMAINS    = 1 << DOM_W;
    localparam int DACR_W     = 2 * DOMAINS;
    localparam int SIZE_STEP  = 4;   // each size code widens the page by 4 address bits

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        AP_PRIV_RW = 2'd0,
        AP_USER_RO = 2'd1,
        AP_ALL_RW  = 2'd2,
        AP_ALL_RO  = 2'd3
    } ap_e;

    typedef enum logic [1:0] {
        DOM_NONE    = 2'd0,
        DOM_CLIENT  = 2'd1,
        DOM_RSVD    = 2'd2,
        DOM_MANAGER = 2'd3
    } dom_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_DOMAIN = 2'd1,
        FLT_PERM   = 2'd2
    } fault_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              global_map;
        pg_size_e          size;
        logic [DOM_W-1:0]  dom;
        ap_e               ap;
    } tlb_entry_t;

    // Bits of the page number that lie inside the page (untranslated).
    function automatic logic [VPN_W-1:0] page_offset_mask(pg_size_e sz);
        logic [VPN_W-1:0] m;
        for (int i = 0; i < VPN_W; i++) begin
            m[i] = (i < SIZE_STEP * int'(sz));
        end
        return m;
    endfunction

    function automatic logic ap_allows(ap_e ap, logic priv, logic wr);
        logic ok;
        case (ap)
            AP_PRIV_RW: ok = priv;
            AP_USER_RO: ok = priv || !wr;
            AP_ALL_RW:  ok = 1'b1;
            default:    ok = !wr;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/utlb_store.sv
module utlb_store
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush_i,
    input  logic                wr_i,
    input  tlb_entry_t          wr_ent_i,
    output logic [ENTRIES-1:0]  valid_o,
    output tlb_entry_t          ent_o [ENTRIES]
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [PTR_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] valid_q;
    tlb_entry_t         ent_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else if (wr_i) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q          <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i && !flush_i) begin
            ent_q[ptr_q] <= wr_ent_i;
        end
    end

    assign valid_o = valid_q;
    assign ent_o   = ent_q;

    // R8: a flush leaves no valid entry behind
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (valid_q == '0));

    // R7: each accepted refill moves the victim pointer one slot on
    p_rr_advance_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !flush_i) |=>
            (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

    // R7: the written slot becomes valid
    p_wr_sets_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !flush_i) |=> ($countones(valid_q) >= 1));

endmodule

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  tlb_entry_t         ent_i [ENTRIES],
    input  logic [VPN_W-1:0]   vpn_i,
    input  logic [ASID_W-1:0]  asid_i,
    output logic               hit_o,
    output logic [VPN_W-1:0]   pvpn_o,
    output logic [DOM_W-1:0]   dom_o,
    output ap_e                ap_o
);
    logic [ENTRIES-1:0] m;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] om;
        logic             id_ok;
        assign om    = page_offset_mask(ent_i[g].size);
        assign id_ok = ent_i[g].global_map || (ent_i[g].asid == asid_i);
        assign m[g]  = valid_i[g] && id_ok &&
                       ((ent_i[g].vpn & ~om) == (vpn_i & ~om));
    end

    logic [VPN_W-1:0] sel_ppn;
    pg_size_e         sel_size;

    // lowest matching slot wins
    always_comb begin
        sel_ppn  = '0;
        sel_size = PG_4K;
        dom_o    = '0;
        ap_o     = AP_PRIV_RW;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (m[i]) begin
                sel_ppn  = ent_i[i].ppn;
                sel_size = ent_i[i].size;
                dom_o    = ent_i[i].dom;
                ap_o     = ent_i[i].ap;
            end
        end
    end

    logic [VPN_W-1:0] sm;
    assign sm     = page_offset_mask(sel_size);
    assign hit_o  = |m;
    assign pvpn_o = (sel_ppn & ~sm) | (vpn_i & sm);

endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
    import utlb_pkg::*;
(
    input  logic [DACR_W-1:0] dacr_i,
    input  logic [DOM_W-1:0]  dom_i,
    input  ap_e               ap_i,
    input  logic              priv_i,
    input  logic              wr_i,
    output fault_e            fault_o
);
    dom_mode_e mode;
    assign mode = dom_mode_e'(dacr_i[{dom_i, 1'b0} +: 2]);

    always_comb begin
        case (mode)
            DOM_CLIENT:  fault_o = ap_allows(ap_i, priv_i, wr_i) ? FLT_NONE : FLT_PERM;
            DOM_MANAGER: fault_o = FLT_NONE;
            default:     fault_o = FLT_DOMAIN;
        endcase
    end
endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic req_valid_i,
    input  logic hit_i,
    input  logic refill_valid_i,
    input  logic flush_i,
    output logic lk_en_o,
    output logic miss_o,
    output logic stall_o,
    output logic accept_o
);
    logic wait_q;

    assign lk_en_o  = req_valid_i && !wait_q;
    assign miss_o   = lk_en_o && !hit_i;
    assign stall_o  = wait_q || miss_o;
    assign accept_o = wait_q && refill_valid_i && !flush_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= 1'b0;
        end else if (accept_o) begin
            wait_q <= 1'b0;
        end else if (miss_o) begin
            wait_q <= 1'b1;
        end
    end

    // R5: a miss leaves the block waiting for a refill
    p_miss_waits_r5: assert property (@(posedge clk) disable iff (rst)
        miss_o |=> stall_o);

    // R5: the stall holds until a refill has been taken
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !accept_o) |=> stall_o);

    // R5: after the refill the held request is looked up again
    p_retry_r5: assert property (@(posedge clk) disable iff (rst)
        (accept_o && req_valid_i) |=> (lk_en_o || !req_valid_i));

    // R6: no refill is taken unless a miss was outstanding
    p_idle_refill_r6: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> $past(stall_o));

endmodule

// File: rtl/utlb.sv
module utlb
    import utlb_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter bit FETCH_SIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic [7:0]  req_asid,
    input  logic        req_write,
    input  logic        req_priv,
    input  logic [31:0] dacr,
    input  logic        flush,
    input  logic        refill_valid,
    input  logic [19:0] refill_vpn,
    input  logic [19:0] refill_ppn,
    input  logic [7:0]  refill_asid,
    input  logic        refill_global,
    input  logic [1:0]  refill_size,
    input  logic [3:0]  refill_domain,
    input  logic [1:0]  refill_ap,
    output logic        hit_o,
    output logic [31:0] pa_o,
    output logic        miss_o,
    output logic        stall_o,
    output logic [1:0]  fault_o,
    output logic        pabort_o,
    output logic        dabort_o
);
    logic [ENTRIES-1:0] valid;
    tlb_entry_t         ents [ENTRIES];
    tlb_entry_t         wr_ent;
    logic               raw_hit, lk_en, accept;
    logic [VPN_W-1:0]   pvpn;
    logic [DOM_W-1:0]   hit_dom;
    ap_e                hit_ap;
    fault_e             chk_fault, fault_w;

    assign wr_ent = '{vpn:        refill_vpn,
                      ppn:        refill_ppn,
                      asid:       refill_asid,
                      global_map: refill_global,
                      size:       pg_size_e'(refill_size),
                      dom:        refill_domain,
                      ap:         ap_e'(refill_ap)};

    utlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (flush),
        .wr_i     (accept),
        .wr_ent_i (wr_ent),
        .valid_o  (valid),
        .ent_o    (ents)
    );

    utlb_match #(.ENTRIES(ENTRIES)) u_match (
        .valid_i (valid),
        .ent_i   (ents),
        .vpn_i   (req_va[VA_W-1:PAGE_SHIFT]),
        .asid_i  (req_asid),
        .hit_o   (raw_hit),
        .pvpn_o  (pvpn),
        .dom_o   (hit_dom),
        .ap_o    (hit_ap)
    );

    utlb_perm u_perm (
        .dacr_i  (dacr),
        .dom_i   (hit_dom),
        .ap_i    (hit_ap),
        .priv_i  (req_priv),
        .wr_i    (req_write),
        .fault_o (chk_fault)
    );

    utlb_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid_i    (req_valid),
        .hit_i          (raw_hit),
        .refill_valid_i (refill_valid),
        .flush_i        (flush),
        .lk_en_o        (lk_en),
        .miss_o         (miss_o),
        .stall_o        (stall_o),
        .accept_o       (accept)
    );

    assign hit_o   = lk_en && raw_hit;
    assign pa_o    = hit_o ? {pvpn, req_va[PAGE_SHIFT-1:0]} : '0;
    assign fault_w = hit_o ? chk_fault : FLT_NONE;
    assign fault_o = fault_w;

    generate
        if (FETCH_SIDE) begin : g_fetch
            assign pabort_o = (fault_w != FLT_NONE);
            assign dabort_o = 1'b0;
        end else begin : g_data
            assign pabort_o = 1'b0;
            assign dabort_o = (fault_w != FLT_NONE);
        end
    endgenerate

    // R11: an abort needs a hit
    p_abort_on_hit_r11: assert property (@(posedge clk) disable iff (rst)
        (pabort_o || dabort_o) |-> hit_o);

    // R11: only one abort kind per instance
    p_one_abort_r11: assert property (@(posedge clk) disable iff (rst)
        !(pabort_o && dabort_o));

    // R5: a hit and a stall never appear together
    p_hit_no_stall_r5: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> !stall_o);

    // R2: the page offset always passes through on a hit
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (pa_o[PAGE_SHIFT-1:0] == req_va[PAGE_SHIFT-1:0]));

endmodule

// File: tb/sim_utlb.sv
module sim_utlb;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_priv = 1;
    logic [31:0] req_va = 0, dacr = 32'h1;
    logic [7:0]  req_asid = 0;
    logic        flush = 0, refill_valid = 0, refill_global = 0;
    logic [19:0] refill_vpn = 0, refill_ppn = 0;
    logic [7:0]  refill_asid = 0;
    logic [1:0]  refill_size = 0, refill_ap = 0;
    logic [3:0]  refill_domain = 0;

    logic        h0, m0, s0, pb0, db0, h1, m1, s1, pb1, db1;
    logic [31:0] pa0, pa1;
    logic [1:0]  f0, f1;

    always #5 clk = ~clk;

    utlb #(.ENTRIES(N), .FETCH_SIDE(1'b0)) u0 (
        .clk, .rst, .req_valid, .req_va, .req_asid, .req_write, .req_priv, .dacr,
        .flush, .refill_valid, .refill_vpn, .refill_ppn, .refill_asid, .refill_global,
        .refill_size, .refill_domain, .refill_ap,
        .hit_o(h0), .pa_o(pa0), .miss_o(m0), .stall_o(s0), .fault_o(f0),
        .pabort_o(pb0), .dabort_o(db0));

    utlb #(.ENTRIES(N), .FETCH_SIDE(1'b1)) u1 (
        .clk, .rst, .req_valid, .req_va, .req_asid, .req_write, .req_priv, .dacr,
        .flush, .refill_valid, .refill_vpn, .refill_ppn, .refill_asid, .refill_global,
        .refill_size, .refill_domain, .refill_ap,
        .hit_o(h1), .pa_o(pa1), .miss_o(m1), .stall_o(s1), .fault_o(f1),
        .pabort_o(pb1), .dabort_o(db1));

    int    checks = 0, errors = 0;
    bit    done = 0, started = 0;
    string cur_req = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_valid [N];
    logic [19:0] m_vpn [N], m_ppn [N];
    logic [7:0]  m_asid [N];
    bit          m_glob [N];
    int          m_size [N], m_dom [N], m_ap [N];
    bit          m_wait = 0;
    int          m_ptr = 0;

    function automatic bit mfind(input logic [31:0] va, input logic [7:0] asid, output int idx);
        idx = 0;
        for (int i = 0; i < N; i++) begin
            int s;
            s = 4 * m_size[i];
            if (m_valid[i] && (m_glob[i] || m_asid[i] == asid) &&
                ((m_vpn[i] >> s) == (va[31:12] >> s))) begin
                idx = i;
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] mpa(input int idx, input logic [31:0] va);
        int s;
        logic [19:0] lm, up;
        s  = 4 * m_size[idx];
        lm = (20'd1 << s) - 20'd1;
        up = m_ppn[idx] & ~lm;
        return {up | (va[31:12] & lm), va[11:0]};
    endfunction

    function automatic int mfault(input int idx, input logic [31:0] dc, input bit pr, input bit wr);
        int  md;
        bit  ok;
        md = int'((dc >> (2 * m_dom[idx])) & 32'h3);
        if (md == 3) return 0;
        if (md != 1) return 1;
        case (m_ap[idx])
            0: ok = pr;
            1: ok = pr || !wr;
            2: ok = 1'b1;
            default: ok = !wr;
        endcase
        return ok ? 0 : 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_wait = 0;
            m_ptr  = 0;
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else begin
            int  ix;
            bit  fnd;
            fnd = mfind(req_va, req_asid, ix);
            if (flush) for (int i = 0; i < N; i++) m_valid[i] = 0;
            if (m_wait) begin
                if (refill_valid && !flush) begin
                    m_valid[m_ptr] = 1;
                    m_vpn[m_ptr]   = refill_vpn;
                    m_ppn[m_ptr]   = refill_ppn;
                    m_asid[m_ptr]  = refill_asid;
                    m_glob[m_ptr]  = refill_global;
                    m_size[m_ptr]  = int'(refill_size);
                    m_dom[m_ptr]   = int'(refill_domain);
                    m_ap[m_ptr]    = int'(refill_ap);
                    m_ptr  = (m_ptr + 1) % N;
                    m_wait = 0;
                end
            end else if (req_valid && !fnd) begin
                m_wait = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            int  ix, ef;
            bit  fnd, lk, eh, em;
            logic [31:0] ep;
            lk  = req_valid && !m_wait;
            fnd = mfind(req_va, req_asid, ix);
            eh  = lk && fnd;
            em  = lk && !fnd;
            ep  = eh ? mpa(ix, req_va) : 32'h0;
            ef  = eh ? mfault(ix, dacr, req_priv, req_write) : 0;
            chk({cur_req, " hit"},   {31'b0, h0}, {31'b0, eh});
            chk({cur_req, " pa"},    pa0, ep);
            chk({cur_req, " miss"},  {31'b0, m0}, {31'b0, em});
            chk({cur_req, " stall"}, {31'b0, s0}, {31'b0, m_wait || em});
            chk({cur_req, " fault"}, {30'b0, f0}, 32'(ef));
            chk({cur_req, " dabort"},{31'b0, db0}, {31'b0, ef != 0});
            chk({cur_req, " pabort data-side"}, {31'b0, pb0}, 32'h0);
            chk({cur_req, " fetch pa"},     pa1, ep);
            chk({cur_req, " fetch stall"},  {31'b0, s1}, {31'b0, m_wait || em});
            chk({cur_req, " fetch pabort"}, {31'b0, pb1}, {31'b0, ef != 0});
            chk({cur_req, " fetch dabort"}, {31'b0, db1}, 32'h0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic look(input logic [31:0] va, input logic [7:0] asid, input bit wr, input bit pr);
        @(posedge clk); #1;
        req_valid = 1; req_va = va; req_asid = asid; req_write = wr; req_priv = pr;
        @(negedge clk);
    endtask

    task automatic resolve(input logic [19:0] ppn, input logic [1:0] sz, input bit glob,
                           input logic [3:0] dom, input logic [1:0] ap);
        @(posedge clk); #1;
        refill_valid = 1; refill_vpn = req_va[31:12]; refill_ppn = ppn; refill_asid = req_asid;
        refill_global = glob; refill_size = sz; refill_domain = dom; refill_ap = ap;
        @(posedge clk); #1;
        refill_valid = 0;
        @(negedge clk);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 0; req_write = 0; req_priv = 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0; started = 1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk("R1 stall after reset", {31'b0, s0}, 0);
        chk("R1 hit after reset", {31'b0, h0}, 0);
        chk("R1 fault after reset", {30'b0, f0}, 0);
        look(32'h1234_5678, 8'd5, 0, 1);
        chk("R1 first lookup misses", {31'b0, m0}, 1);
        // R5: stall holds while waiting
        cur_req = "R5";
        chk("R5 stall in miss cycle", {31'b0, s0}, 1);
        @(negedge clk);
        chk("R5 stall held", {31'b0, s0}, 1);
        chk("R5 no hit while waiting", {31'b0, h0}, 0);
        @(negedge clk);
        chk("R5 miss not repeated", {31'b0, m0}, 0);
        resolve(20'hABCDE, 2'd0, 0, 4'd0, 2'd2);
        // R2: single-cycle hit with 4 KB page
        cur_req = "R2";
        chk("R2 hit after retry", {31'b0, h0}, 1);
        chk("R2 pa 4K", pa0, 32'hABCD_E678);
        chk("R5 stall released", {31'b0, s0}, 0);
        // R4: identifier matching
        cur_req = "R4";
        look(32'h1234_5678, 8'd6, 0, 1);
        chk("R4 other asid misses", {31'b0, m0}, 1);
        resolve(20'h11111, 2'd0, 1, 4'd0, 2'd2);
        chk("R4 global entry pa", pa0, 32'h1111_1678);
        look(32'h1234_5678, 8'd5, 0, 1);
        chk("R4 lowest slot wins", pa0, 32'hABCD_E678);
        look(32'h1234_5FFF, 8'd9, 0, 1);
        chk("R4 global any asid", pa0, 32'h1111_1FFF);
        // R6: idle refill ignored
        cur_req = "R6";
        idle();
        @(posedge clk); #1;
        refill_valid = 1; refill_vpn = 20'h70000; refill_ppn = 20'h77777; refill_asid = 8'd1;
        refill_global = 1; refill_size = 0; refill_domain = 0; refill_ap = 2;
        @(posedge clk); #1 refill_valid = 0;
        look(32'h7000_0010, 8'd1, 0, 1);
        chk("R6 idle refill not written", {31'b0, m0}, 1);
        resolve(20'h77777, 2'd0, 1, 4'd0, 2'd2);
        chk("R6 normal refill pa", pa0, 32'h7777_7010);
        // R3: page sizes
        cur_req = "R3";
        look(32'h2000_ABCD, 8'd1, 0, 1);
        resolve(20'h5555F, 2'd1, 0, 4'd0, 2'd2);
        chk("R3 64K pa", pa0, 32'h5555_ABCD);
        look(32'h2000_1234, 8'd1, 0, 1);
        chk("R3 64K other offset", pa0, 32'h5555_1234);
        look(32'h300F_1234, 8'd1, 0, 1);
        resolve(20'h7A0FF, 2'd2, 0, 4'd0, 2'd2);
        chk("R3 1M pa", pa0, 32'h7A0F_1234);
        look(32'h3000_0008, 8'd1, 0, 1);
        chk("R3 1M base", pa0, 32'h7A00_0008);
        look(32'h40AB_CDEF, 8'd1, 0, 1);
        resolve(20'h9BFFF, 2'd3, 0, 4'd0, 2'd2);
        chk("R3 16M pa", pa0, 32'h9BAB_CDEF);
        look(32'h1234_6678, 8'd5, 0, 1);
        chk("R3 4K boundary miss", {31'b0, m0}, 1);
        resolve(20'h22222, 2'd0, 0, 4'd0, 2'd2);
        // R9 / R11: domain field
        cur_req = "R9";
        look(32'h5000_0000, 8'd1, 0, 1);
        resolve(20'h50505, 2'd0, 0, 4'd3, 2'd3);
        chk("R9 domain 00 faults", {30'b0, f0}, 1);
        chk("R11 data abort", {31'b0, db0}, 1);
        chk("R11 fetch abort", {31'b0, pb1}, 1);
        chk("R11 data side no pabort", {31'b0, pb0}, 0);
        chk("R11 fetch side no dabort", {31'b0, db1}, 0);
        dacr = 32'h0000_0041;
        look(32'h5000_0000, 8'd1, 0, 1);
        chk("R9 client read ok", {30'b0, f0}, 0);
        cur_req = "R10";
        look(32'h5000_0000, 8'd1, 1, 1);
        chk("R10 write to read-only", {30'b0, f0}, 2);
        cur_req = "R9";
        dacr = 32'h0000_00C1;
        look(32'h5000_0000, 8'd1, 1, 0);
        chk("R9 manager bypass", {30'b0, f0}, 0);
        dacr = 32'h0000_0081;
        look(32'h5000_0000, 8'd1, 0, 1);
        chk("R9 domain 10 faults", {30'b0, f0}, 1);
        dacr = 32'h0000_0001;
        // R10: access-bit codes
        cur_req = "R10";
        look(32'h6000_0000, 8'd1, 0, 1);
        resolve(20'h60606, 2'd0, 0, 4'd0, 2'd0);
        look(32'h6000_0000, 8'd1, 0, 0);
        chk("R10 code0 user read", {30'b0, f0}, 2);
        look(32'h6000_0000, 8'd1, 1, 1);
        chk("R10 code0 priv write", {30'b0, f0}, 0);
        look(32'h6100_0000, 8'd1, 0, 1);
        resolve(20'h61616, 2'd0, 0, 4'd0, 2'd1);
        look(32'h6100_0000, 8'd1, 0, 0);
        chk("R10 code1 user read", {30'b0, f0}, 0);
        look(32'h6100_0000, 8'd1, 1, 0);
        chk("R10 code1 user write", {30'b0, f0}, 2);
        look(32'h1234_5678, 8'd5, 1, 0);
        chk("R10 code2 user write", {30'b0, f0}, 0);
        // R8: flush
        cur_req = "R8";
        idle();
        flush = 1;
        @(posedge clk); #1 flush = 0;
        look(32'h1234_5678, 8'd5, 0, 1);
        chk("R8 flushed entry misses", {31'b0, m0}, 1);
        resolve(20'hABCDE, 2'd0, 0, 4'd0, 2'd2);
        // R7: round-robin replacement
        cur_req = "R7";
        for (int i = 0; i <= N; i++) begin
            look(32'h8000_0000 + (i << 12), 8'd1, 0, 1);
            resolve(20'h90000 + 20'(i), 2'd0, 0, 4'd0, 2'd2);
        end
        look(32'h8000_1000, 8'd1, 0, 1);
        chk("R7 second entry kept", pa0, 32'h9000_1000);
        look(32'h8000_0000, 8'd1, 0, 1);
        chk("R7 first entry replaced", {31'b0, m0}, 1);
        resolve(20'h90000, 2'd0, 0, 4'd0, 2'd2);
        idle();
        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule